// File: doc/BRIEF.md
# Periodic Output-Impedance Calibration Sequencer

This block is the digital half of one port's output-driver impedance calibration. An analog comparator, outside the block, reports through a single bit whether the port's drivers are currently weaker than a reference set by an external precision resistor. The sequencer keeps a drive-strength code and moves it one step on each scheduled update. The code feeds every output driver of the port except the test-access outputs. Each port carries its own copy of the sequencer.

Updates fall on a fixed schedule of one every 2**INTERVAL_W port-clock cycles. The first update after master reset marks the end of the initial calibration and raises a ready flag. A strap input, captured during master reset, can switch calibration off. The code is then pinned at the strongest setting. The sequencer holds all of its state in registers clocked by the port clock. While that clock is stopped the code and the position in the schedule are kept, and updates carry on from that point when the clock returns.

Top module: `zq_cal_seq`

## Requirements
- R1: While `mrst` is high with `strap_off` low, and on the first cycle after release, `drv_code` equals mid-scale (only the most significant bit set, 6'b100000 at default width) and `cal_ready` is 0.
- R2: After master reset is released, the first update takes effect on the 2**INTERVAL_W-th rising clock edge. Later updates follow every 2**INTERVAL_W rising edges.
- R3: `cal_ready` stays 0 until the first update takes effect. From then on it stays 1 until the next master reset.
- R4: An update adds one to the code when `cmp_weak` is 1 and subtracts one when it is 0. `cmp_weak` is sampled in the cycle before the update edge. The code never moves by more than one step.
- R5: The code saturates. An upward update at all-ones leaves it at all-ones, and a downward update at zero leaves it at zero.
- R6: Between updates `drv_code` is constant whatever `cmp_weak` does.
- R7: If `strap_off` is 1 in the last cycle that `mrst` is high, then from the first cycle after release `drv_code` is all-ones and `cal_ready` stays 0. No update occurs and `cmp_weak` has no effect until the next master reset.
- R8: Changing `strap_off` while `mrst` is low has no effect on the mode, the code or the schedule.
- R9: While the port clock is stopped, `drv_code` and `cal_ready` hold their values. When the clock resumes, the schedule continues from the cycle count reached before the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| mrst | input | 1 | Synchronous active-high master reset |
| strap_off | input | 1 | Calibration-off strap, captured while mrst is high |
| cmp_weak | input | 1 | Comparator result: 1 means the driver is weaker than the reference |
| drv_code | output | CODE_W | Drive-strength code for the port's output drivers |
| cal_ready | output | 1 | Initial calibration complete |

## Verification
The bench builds the sequencer with CODE_W=4 and INTERVAL_W=4. That gives a 16-cycle update interval and a code range of 0 to 15 that starts at 8. With these values both saturation limits are reached within a few hundred cycles. The update edge can be bracketed exactly, with a check one cycle before it and one on it. A clock stop in the middle of an interval leaves a short enough remainder of the count to check where the schedule picks up after the clock returns.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

    typedef enum logic [1:0] {
        CAL_INIT  = 2'd0,
        CAL_TRACK = 2'd1,
        CAL_OFF   = 2'd2
    } cal_mode_e;

    typedef struct packed {
        logic fire;
        logic up;
    } step_req_t;

    function automatic cal_mode_e mode_from_strap(logic strap);
        return strap ? CAL_OFF : CAL_INIT;
    endfunction

    function automatic cal_mode_e mode_after_fire(cal_mode_e m, logic fire);
        return (m == CAL_INIT && fire) ? CAL_TRACK : m;
    endfunction

endpackage

// File: rtl/zq_interval_timer.sv
module zq_interval_timer #(
    parameter int INTERVAL_W = 10
) (
    input  logic clk,
    input  logic mrst,
    input  logic run,
    output logic fire
);
    logic [INTERVAL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (mrst)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + INTERVAL_W'(1);
    end

    assign fire = run && (cnt_q == {INTERVAL_W{1'b1}});

    // R2: the cycle after an update the count starts over
    assert_count_restarts_R2: assert property (@(posedge clk) disable iff (mrst)
        fire |=> (cnt_q == '0));

    // R2: two updates are never adjacent
    assert_fire_spaced_R2: assert property (@(posedge clk) disable iff (mrst)
        fire |=> !fire);

endmodule

// File: rtl/zq_mode_ctrl.sv
module zq_mode_ctrl
    import zq_cal_pkg::*;
(
    input  logic      clk,
    input  logic      mrst,
    input  logic      strap_off,
    input  logic      fire,
    output cal_mode_e mode,
    output logic      run
);
    cal_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (mrst)
            mode_q <= mode_from_strap(strap_off);
        else
            mode_q <= mode_after_fire(mode_q, fire);
    end

    assign mode = mode_q;
    assign run  = (mode_q != CAL_OFF);

    // R7: the timer never fires while calibration is off
    assert_off_no_fire_R7: assert property (@(posedge clk) disable iff (mrst)
        (mode_q == CAL_OFF) |-> !fire);

    // R8: the off mode is only left through master reset
    assert_off_sticky_R8: assert property (@(posedge clk) disable iff (mrst)
        (mode_q == CAL_OFF) |=> (mode_q == CAL_OFF));

endmodule

// File: rtl/zq_code_stepper.sv
module zq_code_stepper
    import zq_cal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              mrst,
    input  step_req_t         req,
    input  logic              force_max,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_next;

    always_comb begin
        code_next = code_q;
        if (req.up) begin
            if (code_q != CODE_MAX)
                code_next = code_q + CODE_W'(1);
        end else begin
            if (code_q != '0)
                code_next = code_q - CODE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (mrst)
            code_q <= CODE_MID;
        else if (req.fire)
            code_q <= code_next;
    end

    assign code = force_max ? CODE_MAX : code_q;

    // R6: no movement without a scheduled update
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (mrst)
        !req.fire |=> $stable(code_q));

    // R4: at most one step per update
    assert_single_step_R4: assert property (@(posedge clk) disable iff (mrst)
        req.fire |=> ((code_q == $past(code_q) + CODE_W'(1)) ||
                      (code_q == $past(code_q) - CODE_W'(1)) ||
                      $stable(code_q)));

    // R5: no wrap at the top
    assert_no_wrap_high_R5: assert property (@(posedge clk) disable iff (mrst)
        (req.fire && req.up && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

    // R5: no wrap at the bottom
    assert_no_wrap_low_R5: assert property (@(posedge clk) disable iff (mrst)
        (req.fire && !req.up && code_q == '0) |=> (code_q == '0));

endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
    import zq_cal_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int INTERVAL_W = 10
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              strap_off,
    input  logic              cmp_weak,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_ready
);
    cal_mode_e mode;
    logic      run;
    logic      fire;
    step_req_t req;

    zq_interval_timer #(.INTERVAL_W(INTERVAL_W)) timer_i (
        .clk  (clk),
        .mrst (mrst),
        .run  (run),
        .fire (fire)
    );

    zq_mode_ctrl mode_i (
        .clk       (clk),
        .mrst      (mrst),
        .strap_off (strap_off),
        .fire      (fire),
        .mode      (mode),
        .run       (run)
    );

    assign req.fire = fire;
    assign req.up   = cmp_weak;

    zq_code_stepper #(.CODE_W(CODE_W)) step_i (
        .clk       (clk),
        .mrst      (mrst),
        .req       (req),
        .force_max (mode == CAL_OFF),
        .code      (drv_code)
    );

    assign cal_ready = (mode == CAL_TRACK);

    // R3: once ready, stays ready until reset
    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (mrst)
        cal_ready |=> cal_ready);

    // R3: ready rises only with an update
    assert_ready_on_fire_R3: assert property (@(posedge clk) disable iff (mrst)
        (!cal_ready && !fire) |=> !cal_ready);

    // R7: strap high at release gives the strongest code and no ready
    assert_disabled_strong_R7: assert property (@(posedge clk) disable iff (mrst)
        ($past(mrst) && $past(strap_off)) |-> (drv_code == {CODE_W{1'b1}} && !cal_ready));

endmodule

// File: tb/zq_cal_seq_tb.sv
module zq_cal_seq_tb_top;
    localparam int CW  = 4;
    localparam int IW  = 4;
    localparam int PER = 1 << IW;
    localparam logic [CW-1:0] MID = 4'd8;
    localparam logic [CW-1:0] MAX = 4'd15;

    logic          clk = 1'b0;
    logic          clk_run = 1'b1;
    logic          mrst = 1'b1;
    logic          strap_off = 1'b0;
    logic          cmp_weak = 1'b0;
    logic [CW-1:0] drv_code;
    logic          cal_ready;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    zq_cal_seq #(.CODE_W(CW), .INTERVAL_W(IW)) dut_i (
        .clk       (clk),
        .mrst      (mrst),
        .strap_off (strap_off),
        .cmp_weak  (cmp_weak),
        .drv_code  (drv_code),
        .cal_ready (cal_ready)
    );

    always begin
        #4;
        if (clk_run) clk = ~clk;
    end

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [CW-1:0] exp_code, input logic exp_rdy);
        n_checks++;
        if (drv_code !== exp_code || cal_ready !== exp_rdy) begin
            n_errors++;
            $display("FAIL %s: code=%0d ready=%0b expected code=%0d ready=%0b",
                     req, drv_code, cal_ready, exp_code, exp_rdy);
        end
    endtask

    function automatic logic [CW-1:0] model_step(input logic [CW-1:0] c, input logic up);
        if (up) return (c == MAX) ? MAX : c + 1'b1;
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    task automatic do_reset(input logic s);
        @(negedge clk);
        mrst = 1'b1;
        strap_off = s;
        edges(2);
        mrst = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        mrst = 1'b1;
        strap_off = 1'b0;
        edges(2);
        chk("R1 in reset", MID, 1'b0);
        mrst = 1'b0;
        edges(1);
        chk("R1 after release", MID, 1'b0);
    endtask

    task automatic t_first_updates();
        cmp_weak = 1'b1;
        do_reset(1'b0);
        edges(PER - 1);
        chk("R2 R3 before first update", MID, 1'b0);
        cmp_weak = 1'b0;  // R4: sampled value is the one before the edge
        cmp_weak = 1'b1;
        edges(1);
        chk("R2 R3 R4 first update up", MID + 1'b1, 1'b1);
        cmp_weak = 1'b0;
        edges(PER / 2);
        cmp_weak = 1'b1;
        edges(PER / 2 - 2);
        chk("R6 hold between updates", MID + 1'b1, 1'b1);
        cmp_weak = 1'b0;
        edges(1);
        chk("R6 hold one before update", MID + 1'b1, 1'b1);
        edges(1);
        chk("R2 R4 second update down", MID, 1'b1);
    endtask

    task automatic t_saturate_high();
        logic [CW-1:0] exp_c = MID;
        cmp_weak = 1'b1;
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) begin
            edges(PER);
            exp_c = model_step(exp_c, 1'b1);
        end
        chk("R5 saturate high", exp_c, 1'b1);
        chk("R5 top value", MAX, 1'b1);
    endtask

    task automatic t_saturate_low();
        logic [CW-1:0] exp_c = MID;
        cmp_weak = 1'b0;
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) begin
            edges(PER);
            exp_c = model_step(exp_c, 1'b0);
        end
        chk("R5 saturate low", exp_c, 1'b1);
        chk("R5 bottom value", '0, 1'b1);
    endtask

    task automatic t_disabled();
        cmp_weak = 1'b0;
        do_reset(1'b1);
        edges(1);
        chk("R7 strongest after release", MAX, 1'b0);
        strap_off = 1'b0;
        for (int i = 0; i < 3 * PER; i++) begin
            cmp_weak = ~cmp_weak;
            edges(1);
        end
        chk("R7 R8 no updates while off", MAX, 1'b0);
    endtask

    task automatic t_strap_after_reset();
        cmp_weak = 1'b0;
        do_reset(1'b0);
        strap_off = 1'b1;
        edges(PER);
        chk("R8 late strap ignored", MID - 1'b1, 1'b1);
        strap_off = 1'b0;
    endtask

    task automatic t_clock_stop();
        cmp_weak = 1'b1;
        do_reset(1'b0);
        edges(10);
        clk_run = 1'b0;
        #200;
        chk("R9 held while stopped", MID, 1'b0);
        clk_run = 1'b1;
        edges(PER - 10 - 1);
        chk("R9 schedule resumes", MID, 1'b0);
        edges(1);
        chk("R9 update after resume", MID + 1'b1, 1'b1);
        edges(3);
        clk_run = 1'b0;
        #120;
        chk("R9 held after update", MID + 1'b1, 1'b1);
        clk_run = 1'b1;
        edges(PER - 3);
        chk("R9 next update on time", MID + 2'd2, 1'b1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_first_updates();
        t_saturate_high();
        t_saturate_low();
        t_disabled();
        t_strap_after_reset();
        t_clock_stop();
        finish_run();
    end

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

endmodule